// File: doc/BRIEF.md
# Prescaled Timer Counter with Access-Triggered Flag Clearing

This block is a free-running 16-bit counter that advances on ticks from a prescaler. The prescaler has two modes. A legacy mode divides the clock by a power of two. A precision mode divides it by an 8-bit value plus one. A mode bit chooses between them, and that bit can be written only once after reset. The counter sets an overflow flag each time it wraps.

The block also has eight channels. Each channel works either as an input capture or as an output compare, and each has its own event flag. Two more flags come from an external pulse accumulator: one for its overflow and one for an input edge. The accumulator's counting logic lives outside this block; only its flags are held here.

Software reaches everything through a byte-wide register bus that has an address, a read strobe, a write strobe and write data. Read data is combinational. Flags are always cleared by writing ones to the flag registers. When the fast-clear control bit is set, they are also cleared as a side effect of touching the data register they belong to.

Top module: `tmr_fastclr`

## Requirements
- R1: Reset state. After reset the counter reads 0x0000. All flag registers read 0. The control register (address 0x00) reads 0. The control register holds EN in bit 0, FAST in bit 1 and PMODE in bit 2.
- R2: Counting. While EN is 1, the counter (high byte at 0x04, low byte at 0x05) advances by one on every prescaler tick. While EN is 0 it holds its value. Writes to the counter addresses do not change it.
- R3: Legacy prescaler. With PMODE at 0, a tick comes once every 2^N clocks, where N is bits [2:0] of address 0x01. The count of clocks starts on the edge that sets EN.
- R4: Precision prescaler. With PMODE at 1, a tick comes once every P+1 clocks, where P is the 8-bit value at address 0x02.
- R5: Write-once mode bit. The first write to the control register after reset sets PMODE. Every later write leaves PMODE unchanged, while EN and FAST still update.
- R6: Overflow flag. When a tick moves the counter from 0xFFFF to 0x0000, bit 0 of address 0x07 is set.
- R7: Channels. Channel n has its 16-bit data register at 0x10+2n (high byte) and 0x11+2n (low byte). Bit n of address 0x03 selects compare mode (1) or capture mode (0). In capture mode, a pulse on ch_evt[n] copies the counter value into the data register and sets bit n of address 0x06. In compare mode, bit n is set on the tick that brings the counter to the data register value.
- R8: Write-one-to-clear. For the flag registers 0x06 (channels), 0x07 (overflow) and 0x08 (bit 0 accumulator overflow, bit 1 accumulator edge), writing 1 to a bit clears it and writing 0 leaves it unchanged. With FAST at 0, reads and writes of the data registers leave every flag unchanged.
- R9: Fast clear of channel flags. With FAST at 1, reading either byte of a channel in capture mode clears its flag. Writing either byte of a channel in compare mode clears its flag. Writing a capture channel or reading a compare channel leaves the flag set.
- R10: Fast clear of the overflow flag. With FAST at 1, a read or write of either counter byte clears the overflow flag.
- R11: Fast clear of the accumulator flags. With FAST at 1, a read or write of either accumulator count byte (0x0A, 0x0B, which read as 0) clears both accumulator flags.
- R12: Set wins. When an event that sets a flag and an access that clears it fall in the same cycle, the flag ends the cycle set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 6 | Register address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| ch_evt | input | 8 | Per-channel capture event pulses |
| acc_ovf_evt | input | 1 | Accumulator overflow event pulse |
| acc_edge_evt | input | 1 | Accumulator input-edge event pulse |

## Verification
A flag can be set and cleared in the same clock. One source sets it: a channel event, a compare match, a counter wrap or an accumulator pulse. The other clears it: a write-one or a fast side-effect access. The bench makes these collide by driving an event pulse in the same cycle as a clearing access. It does this with a capture event during a fast read of that channel, and with an accumulator overflow during a fast access of the accumulator count. A collision passes only if the colliding flag ends set, while any other flag that was cleared by the same access ends clear.

// File: rtl/tmr_fastclr_pkg.sv
package tmr_fastclr_pkg;
  localparam int CNT_W    = 16;
  localparam int PRE_W    = 8;
  localparam int LSEL_W   = 3;
  localparam int A_CTRL   = 'h00;
  localparam int A_LSEL   = 'h01;
  localparam int A_PSEL   = 'h02;
  localparam int A_CHMODE = 'h03;
  localparam int A_CNTH   = 'h04;
  localparam int A_CNTL   = 'h05;
  localparam int A_CHFLG  = 'h06;
  localparam int A_OVFLG  = 'h07;
  localparam int A_ACCFLG = 'h08;
  localparam int A_ACCH   = 'h0A;
  localparam int A_ACCL   = 'h0B;
  localparam int A_CHAN   = 'h10;
  localparam int B_EN     = 0;
  localparam int B_FAST   = 1;
  localparam int B_PMODE  = 2;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_fastclr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pmode,
  input  logic [LSEL_W-1:0] lsel,
  input  logic [PRE_W-1:0]  psel,
  output logic              tick
);
  logic [PRE_W-1:0] pre_q, pre_d, limit;

  always_comb begin
    limit = pmode ? psel : PRE_W'((1 << lsel) - 1);
    tick  = en && (pre_q == limit);
    if (!en || tick) pre_d = '0;
    else             pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick); // R2
endmodule

// File: rtl/tmr_flagbank.sv
module tmr_flagbank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flag
);
  logic [W-1:0] flag_d;

  always_comb flag_d = (flag & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= '0;
    else        flag <= flag_d;
  end

  for (genvar k = 0; k < W; k++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[k] |=> flag[k]); // R12
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!set[k] && !clr[k]) |=> $stable(flag[k])); // R8
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_fastclr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_mode,
  input  logic             evt,
  input  logic             cnt_tick,
  input  logic [CNT_W-1:0] cnt_cur,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] data,
  output logic             hit
);
  logic [CNT_W-1:0] data_d;
  logic             cap;

  always_comb begin
    cap    = !cmp_mode && evt;
    hit    = cmp_mode ? (cnt_tick && (cnt_nxt == data)) : evt;
    data_d = data;
    if (cap) begin
      data_d = cnt_cur;
    end else begin
      if (wr_hi) data_d[15:8] = wdata;
      if (wr_lo) data_d[7:0]  = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data <= '0;
    else        data <= data_d;
  end

  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_mode && evt) |=> (data == $past(cnt_cur))); // R7
endmodule

// File: rtl/tmr_fastclr.sv
module tmr_fastclr
  import tmr_fastclr_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic           rd_en,
  input  logic           wr_en,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  input  logic [NCH-1:0] ch_evt,
  input  logic           acc_ovf_evt,
  input  logic           acc_edge_evt
);
  localparam int CHAN_BASE = A_CHAN >> 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // configuration registers
  logic              en_q, fast_q, pmode_q, lock_q;
  logic              en_d, fast_d, pmode_d, lock_d;
  logic [LSEL_W-1:0] lsel_q, lsel_d;
  logic [PRE_W-1:0]  psel_q, psel_d;
  logic [NCH-1:0]    mode_q, mode_d;
  logic              wr_ctrl;

  always_comb begin
    wr_ctrl = wr_en && (int'(addr) == A_CTRL);
    en_d    = en_q;
    fast_d  = fast_q;
    pmode_d = pmode_q;
    lock_d  = lock_q;
    lsel_d  = lsel_q;
    psel_d  = psel_q;
    mode_d  = mode_q;
    if (wr_ctrl) begin
      en_d   = wdata[B_EN];
      fast_d = wdata[B_FAST];
      lock_d = 1'b1;
      if (!lock_q) pmode_d = wdata[B_PMODE];
    end
    if (wr_en && int'(addr) == A_LSEL)   lsel_d = wdata[LSEL_W-1:0];
    if (wr_en && int'(addr) == A_PSEL)   psel_d = wdata[PRE_W-1:0];
    if (wr_en && int'(addr) == A_CHMODE) mode_d = wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      en_q    <= 1'b0;
      fast_q  <= 1'b0;
      pmode_q <= 1'b0;
      lock_q  <= 1'b0;
      lsel_q  <= '0;
      psel_q  <= '0;
      mode_q  <= '0;
    end else begin
      en_q    <= en_d;
      fast_q  <= fast_d;
      pmode_q <= pmode_d;
      lock_q  <= lock_d;
      lsel_q  <= lsel_d;
      psel_q  <= psel_d;
      mode_q  <= mode_d;
    end
  end

  // prescaler and counter
  logic             tick;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, cnt_d;

  tmr_prescale u_pre (
    .clk   (clk),
    .rst_n (rst_q),
    .en    (en_q),
    .pmode (pmode_q),
    .lsel  (lsel_q),
    .psel  (psel_q),
    .tick  (tick)
  );

  always_comb begin
    cnt_nxt = cnt_q + 1'b1;
    cnt_d   = tick ? cnt_nxt : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // channels
  logic [NCH-1:0]   ch_sel, ch_hit, ch_clr, ch_flag;
  logic [CNT_W-1:0] ch_data [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_sel[i] = (int'(addr) >> 1) == (CHAN_BASE + i);

    tmr_chan u_ch (
      .clk      (clk),
      .rst_n    (rst_q),
      .cmp_mode (mode_q[i]),
      .evt      (ch_evt[i]),
      .cnt_tick (tick),
      .cnt_cur  (cnt_q),
      .cnt_nxt  (cnt_nxt),
      .wr_hi    (wr_en && ch_sel[i] && !addr[0]),
      .wr_lo    (wr_en && ch_sel[i] &&  addr[0]),
      .wdata    (wdata),
      .data     (ch_data[i]),
      .hit      (ch_hit[i])
    );

    assign ch_clr[i] = (wr_en && int'(addr) == A_CHFLG && wdata[i])
                     | (fast_q && ch_sel[i] &&
                        ((!mode_q[i] && rd_en) || (mode_q[i] && wr_en)));
  end

  // overflow and accumulator flags
  logic       acc_touch, cnt_touch, ovf_set, ovf_clr, ovf_flag;
  logic [1:0] acc_set, acc_clr, acc_flag;

  always_comb begin
    cnt_touch = (rd_en || wr_en) && (int'(addr) == A_CNTH || int'(addr) == A_CNTL);
    acc_touch = (rd_en || wr_en) && (int'(addr) == A_ACCH || int'(addr) == A_ACCL);
    ovf_set   = tick && (&cnt_q);
    ovf_clr   = (wr_en && int'(addr) == A_OVFLG && wdata[0]) || (fast_q && cnt_touch);
    acc_set   = {acc_edge_evt, acc_ovf_evt};
    acc_clr   = ({2{wr_en && int'(addr) == A_ACCFLG}} & wdata[1:0])
              | {2{fast_q && acc_touch}};
  end

  tmr_flagbank #(.W(NCH)) u_chflg (
    .clk (clk), .rst_n (rst_q), .set (ch_hit), .clr (ch_clr), .flag (ch_flag)
  );

  tmr_flagbank #(.W(1)) u_ovflg (
    .clk (clk), .rst_n (rst_q), .set (ovf_set), .clr (ovf_clr), .flag (ovf_flag)
  );

  tmr_flagbank #(.W(2)) u_accflg (
    .clk (clk), .rst_n (rst_q), .set (acc_set), .clr (acc_clr), .flag (acc_flag)
  );

  // read mux
  always_comb begin
    rdata = '0;
    case (int'(addr))
      A_CTRL:   rdata = {5'b0, pmode_q, fast_q, en_q};
      A_LSEL:   rdata = 8'(lsel_q);
      A_PSEL:   rdata = 8'(psel_q);
      A_CHMODE: rdata = 8'(mode_q);
      A_CNTH:   rdata = cnt_q[15:8];
      A_CNTL:   rdata = cnt_q[7:0];
      A_CHFLG:  rdata = 8'(ch_flag);
      A_OVFLG:  rdata = {7'b0, ovf_flag};
      A_ACCFLG: rdata = {6'b0, acc_flag};
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (ch_sel[i]) rdata = addr[0] ? ch_data[i][7:0] : ch_data[i][15:8];
        end
      end
    endcase
  end

  AST_PMODE_LOCK: assert property (@(posedge clk) disable iff (!rst_q)
    lock_q |=> $stable(pmode_q)); // R5
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_q)
    (tick && cnt_q == 16'hFFFF) |=> (ovf_flag && cnt_q == 16'h0000)); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    !en_q |=> $stable(cnt_q)); // R2
  AST_FAST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_q)
    (fast_q && cnt_touch && !ovf_set) |=> !ovf_flag); // R10
endmodule

// File: tb/tmr_fastclr_test.sv
module tmr_fastclr_test;
  logic       clk, rst_n, rd_en, wr_en, acc_ovf_evt, acc_edge_evt;
  logic [5:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] ch_evt;
  int total = 0;
  int bad   = 0;

  tmr_fastclr uut (
    .clk (clk), .rst_n (rst_n), .addr (addr), .rd_en (rd_en), .wr_en (wr_en),
    .wdata (wdata), .rdata (rdata), .ch_evt (ch_evt),
    .acc_ovf_evt (acc_ovf_evt), .acc_edge_evt (acc_edge_evt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    ch_evt = '0; acc_ovf_evt = 1'b0; acc_edge_evt = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 6'(a); wdata = 8'(d); wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = 6'(a); rd_en = 1'b1;
    #1 d = int'(rdata);
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    rd('h00, v); chk("R1 ctrl", v, 0);
    rd('h04, v); chk("R1 cnt hi", v, 0);
    rd('h05, v); chk("R1 cnt lo", v, 0);
    rd('h06, v); chk("R1 chflg", v, 0);
    rd('h07, v); chk("R1 ovflg", v, 0);
    rd('h08, v); chk("R1 accflg", v, 0);
  endtask

  task automatic t_legacy();
    int v, a;
    do_reset();
    wr('h01, 2);
    wr('h00, 1);
    repeat (40) @(posedge clk);
    rd('h05, v); chk("R3 div4 lo", v, 10);
    rd('h04, v); chk("R3 div4 hi", v, 0);
    wr('h00, 0);
    rd('h05, a);
    repeat (20) @(posedge clk);
    wr('h05, 'hAA);
    rd('h05, v); chk("R2 hold when EN=0", v, a);
    do_reset();
    wr('h01, 7);
    wr('h00, 1);
    repeat (256) @(posedge clk);
    rd('h05, v); chk("R3 div128", v, 2);
  endtask

  task automatic t_precision();
    int v;
    do_reset();
    wr('h02, 4);
    wr('h00, 5);
    repeat (40) @(posedge clk);
    rd('h05, v); chk("R4 div5", v, 8);
  endtask

  task automatic t_pmode_once();
    int v;
    do_reset();
    wr('h00, 4);
    wr('h00, 2);
    rd('h00, v); chk("R5 pmode kept at 1, fast updated", v, 6);
    do_reset();
    wr('h00, 0);
    wr('h00, 4);
    rd('h00, v); chk("R5 pmode kept at 0", v, 0);
  endtask

  task automatic t_overflow();
    int v;
    do_reset();
    wr('h00, 1);
    repeat (65535) @(posedge clk);
    rd('h07, v); chk("R6 no flag before wrap", v, 0);
    rd('h07, v); chk("R6 flag after wrap", v, 1);
    rd('h05, v);
    wr('h04, 0);
    rd('h07, v); chk("R8 counter access no clear when FAST=0", v, 1);
    wr('h07, 0);
    rd('h07, v); chk("R8 write 0 keeps", v, 1);
    wr('h00, 3);
    rd('h04, v);
    rd('h07, v); chk("R10 fast read clears overflow", v, 0);
  endtask

  task automatic t_capture();
    int v;
    do_reset();
    wr('h00, 1);
    repeat (9) @(posedge clk);
    @(negedge clk); ch_evt[3] = 1'b1;
    @(posedge clk); #1 ch_evt[3] = 1'b0;
    rd('h06, v); chk("R7 capture flag", v, 'h08);
    rd('h16, v); chk("R7 capture hi", v, 0);
    rd('h17, v); chk("R7 capture lo", v, 9);
    rd('h06, v); chk("R8 reads leave flag", v, 'h08);
    wr('h00, 3);
    wr('h17, 'h55);
    rd('h06, v); chk("R9 write of capture keeps flag", v, 'h08);
    rd('h16, v);
    rd('h06, v); chk("R9 fast read clears capture flag", v, 0);
  endtask

  task automatic t_compare();
    int v;
    do_reset();
    wr('h03, 'h20);
    wr('h1A, 0);
    wr('h1B, 20);
    wr('h00, 1);
    repeat (19) @(posedge clk);
    rd('h06, v); chk("R7 no match yet", v, 0);
    rd('h06, v); chk("R7 compare match flag", v, 'h20);
    wr('h00, 3);
    rd('h1B, v);
    rd('h06, v); chk("R9 read of compare keeps flag", v, 'h20);
    wr('h1B, 200);
    rd('h06, v); chk("R9 fast write clears compare flag", v, 0);
  endtask

  task automatic t_accum();
    int v;
    do_reset();
    @(negedge clk); acc_ovf_evt = 1'b1; acc_edge_evt = 1'b1;
    @(posedge clk); #1 acc_ovf_evt = 1'b0; acc_edge_evt = 1'b0;
    rd('h08, v); chk("R11 both acc flags set", v, 3);
    rd('h0A, v);
    rd('h08, v); chk("R8 acc access no clear when FAST=0", v, 3);
    wr('h08, 1);
    rd('h08, v); chk("R8 w1c clears only bit0", v, 2);
    wr('h00, 2);
    wr('h0B, 0);
    rd('h08, v); chk("R11 fast write clears both", v, 0);
    @(negedge clk); acc_ovf_evt = 1'b1; acc_edge_evt = 1'b1;
    @(posedge clk); #1 acc_ovf_evt = 1'b0; acc_edge_evt = 1'b0;
    @(negedge clk); addr = 6'h0A; rd_en = 1'b1; acc_ovf_evt = 1'b1;
    @(posedge clk); #1 rd_en = 1'b0; acc_ovf_evt = 1'b0;
    rd('h08, v); chk("R12 acc set wins, edge cleared", v, 1);
  endtask

  task automatic t_set_wins();
    int v;
    do_reset();
    wr('h00, 2);
    @(negedge clk); ch_evt[1] = 1'b1;
    @(posedge clk); #1 ch_evt[1] = 1'b0;
    @(negedge clk); addr = 6'h13; rd_en = 1'b1; ch_evt[1] = 1'b1;
    @(posedge clk); #1 rd_en = 1'b0; ch_evt[1] = 1'b0;
    rd('h06, v); chk("R12 channel set wins", v, 'h02);
    rd('h13, v);
    rd('h06, v); chk("R9 fast read then clears", v, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_legacy();
    t_precision();
    t_pmode_once();
    t_capture();
    t_compare();
    t_accum();
    t_set_wins();
    t_overflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule